// File: doc/BRIEF.md
# Bit-Serial Multiplier-Free Inner Product Engine

This block forms the inner product of K fixed coefficients with K signed fractional input samples, and uses no multiplier. A one-cycle start pulse captures all K input words in parallel. On each following clock one bit is taken from every word at the same weight, least significant weight first. Those K bits form an index into a precomputed table. Each table entry is the sum of the coefficients whose index bit is set. The selected entry enters a scaled accumulator. After N such steps the exact result is presented, marked by a one-cycle valid pulse.

The coefficients are design parameters in signed Q2.14 form (CW = 16 bits). Each sample is an N-bit two's-complement fraction whose most significant bit carries weight −1. The result is the exact integer sum of coefficient-code × sample-code, so its weight is 2^−(14+N−1). The result port is wide enough that the worst case cannot overflow. The defaults are K = 4 and N = 8, with the coefficients 0.72, −0.30, 0.95 and 0.11. These are stored as the codes 11796, −4915, 15565 and 1802 for lanes 0 to 3. The result port is RW = CW + N + clog2(K) + 1 = 27 bits wide.

Top module: `da_dot_serial`

## Requirements
- R1: While reset is applied, and in the first cycle after reset is released, `busy` and `valid` are 0 and `result` is 0.
- R2: `valid` rises exactly N clock edges after the edge that accepts a start, and stays high for exactly one cycle.
- R3: The value on `result` at a valid pulse equals Σ C_k·X_k, with no rounding or overflow. C_k is coefficient code k and X_k is the signed value of lane k, taken from `din[k*N +: N]`. This holds for the extreme inputs too: every lane at −2^(N−1), and every lane at 2^(N−1)−1.
- R4: Lane k supplies index bit K−1−k, and each table entry is the sum of the selected coefficients. With lane LSBs only, the lane patterns 1111, 0110 and 0101 (lanes 0..3) produce 24248, 10650 and −3113. These are 1.48, 0.65 and −0.19 in Q2.14.
- R5: The sign-bit step subtracts its table entry. A single lane k at −2^(N−1) with all other lanes at 0 gives −C_k·2^(N−1).
- R6: A start that arrives while `busy` is 1 is ignored. Changes on `din` after a start has been accepted have no effect on that result.
- R7: A start presented in the cycle where `valid` is high is accepted. A start held high continuously therefore yields one result every N+1 cycles.
- R8: `busy` is 1 from the edge that accepts a start through the edge that raises `valid`, where it returns to 0.
- R9: `result` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture `din` and begin a computation when not busy |
| din | input | K*N | Packed input samples, lane k at bits [k*N +: N] |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle pulse: `result` has just been updated |
| result | output | RW | Signed inner product, weight 2^−(14+N−1) |

## Verification
Two events can share one cycle. A start can arrive on the edge that performs the sign-bit subtraction and raises `valid`. A start can also arrive in the cycle where `valid` is high. The first start must be ignored and the second must be accepted. The bench provokes both by holding `start` high for long runs while `din` changes every cycle, and by inserting single starts at random gaps. A behavioural model tracks acceptance, latency and the expected integer dot product of the captured words. It judges `busy`, `valid` and `result` on every clock.

// File: rtl/dadot_pkg.sv
package dadot_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/da_lane_shift.sv
// K parallel capture registers; each shifts right once per step and its
// LSB contributes one table index bit (lane k -> index bit K-1-k).
module da_lane_shift #(
    parameter int K = 4,
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic [K*N-1:0] din,
    output logic [K-1:0]   idx
);
    logic [K-1:0][N-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = din;
        end else if (shift) begin
            for (int k = 0; k < K; k++) begin
                sr_d[k] = {1'b0, sr_q[k][N-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    for (genvar k = 0; k < K; k++) begin : g_idx
        assign idx[K-1-k] = sr_q[k][0];
    end
endmodule

// File: rtl/da_psum_rom.sv
// Table of 2^K coefficient partial sums, built from the parameter.
module da_psum_rom #(
    parameter int             K     = 4,
    parameter int             CW    = 16,
    parameter int             TW    = CW + $clog2(K),
    parameter logic [K*CW-1:0] COEFS = '0
) (
    input  logic [K-1:0]         idx,
    output logic signed [TW-1:0] psum
);
    localparam int DEPTH = 1 << K;

    function automatic logic signed [TW-1:0] entry_f(input logic [K-1:0] a);
        logic signed [TW-1:0] s;
        logic signed [CW-1:0] c;
        s = '0;
        for (int k = 0; k < K; k++) begin
            c = COEFS[k*CW +: CW];
            if (a[K-1-k]) s = s + TW'(c);
        end
        return s;
    endfunction

    logic signed [TW-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign rom[a] = entry_f(K'(a));
    end

    assign psum = rom[idx];
endmodule

// File: rtl/da_accum.sv
// Scaled accumulator: add-then-halve for ordinary bits, subtract for the
// sign bit. Partial sums enter pre-scaled by 2^(N-1) so no bit is lost.
module da_accum #(
    parameter int TW = 18,
    parameter int N  = 8,
    parameter int AW = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 last,
    input  logic signed [TW-1:0] psum,
    output logic signed [AW-1:0] acc_nx
);
    logic signed [AW-1:0] acc_d, acc_q;
    logic signed [AW-1:0] addend;
    logic signed [AW-1:0] sum;

    always_comb begin
        addend = AW'(psum) <<< (N-1);
        sum    = acc_q + addend;
        acc_d  = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (step) begin
            if (last) acc_d = acc_q - addend;
            else      acc_d = sum >>> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_nx = acc_d;
endmodule

// File: rtl/da_seq.sv
// Step sequencer: accepts a start when idle, runs N steps, pulses valid.
module da_seq
    import dadot_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic valid
);
    localparam int CNTW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        phase_e          phase;
        logic [CNTW-1:0] cnt;
        logic            vld;
    } seq_t;

    seq_t st_d, st_q;

    assign busy  = (st_q.phase == PH_RUN);
    assign valid = st_q.vld;
    assign step  = busy;
    assign last  = busy && (st_q.cnt == CNTW'(N-1));
    assign load  = start && !busy;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (busy) begin
            if (last) begin
                st_d.phase = PH_IDLE;
                st_d.vld   = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0, vld: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/da_dot_serial.sv
module da_dot_serial #(
    parameter int              K     = 4,
    parameter int              N     = 8,
    parameter int              CW    = 16,
    parameter logic [K*CW-1:0] COEFS = {16'd1802, 16'd15565, 16'hECCD, 16'd11796},
    localparam int             RW    = CW + N + $clog2(K) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [K*N-1:0]       din,
    output logic                 busy,
    output logic                 valid,
    output logic signed [RW-1:0] result
);
    localparam int TW = CW + $clog2(K);

    logic                 load, step, last;
    logic [K-1:0]         idx;
    logic signed [TW-1:0] psum;
    logic signed [RW-1:0] acc_nx;
    logic signed [RW-1:0] result_d, result_q;

    da_seq #(.N(N)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .last(last),
        .busy(busy), .valid(valid)
    );

    da_lane_shift #(.K(K), .N(N)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
        .din(din), .idx(idx)
    );

    da_psum_rom #(.K(K), .CW(CW), .TW(TW), .COEFS(COEFS)) u_rom (
        .idx(idx), .psum(psum)
    );

    da_accum #(.TW(TW), .N(N), .AW(RW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
        .last(last), .psum(psum), .acc_nx(acc_nx)
    );

    always_comb begin
        result_d = result_q;
        if (last) result_d = acc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_q <= '0;
        else        result_q <= result_d;
    end

    assign result = result_q;
endmodule

// File: rtl/da_dot_serial_chk.sv
module da_dot_serial_chk #(
    parameter int N  = 8,
    parameter int RW = 27
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          valid,
    input logic [RW-1:0] result
);
    localparam int LW = $clog2(N + 2) + 1;

    logic [LW-1:0] since_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (start && !busy) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && since_q <= LW'(N)) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (armed_q && since_q == LW'(N)));

    p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !valid));

    p_idle_at_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || valid));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(result));
endmodule

bind da_dot_serial da_dot_serial_chk #(.N(N), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .valid(valid), .result(result)
);

// File: tb/sim_da_dot_serial.sv
`timescale 1ns/1ps
module sim_da_dot_serial;
    localparam int K  = 4;
    localparam int N  = 8;
    localparam int CW = 16;
    localparam int RW = CW + N + $clog2(K) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [K*N-1:0]       din = '0;
    logic                 busy, valid;
    logic signed [RW-1:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;
    string cur_tag = "R3";

    longint coef [K] = '{11796, -4915, 15565, 1802};

    da_dot_serial #(.K(K), .N(N), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .busy(busy), .valid(valid), .result(result)
    );

    always #2 clk = ~clk;

    function automatic longint dot_f(input logic [K*N-1:0] d);
        longint s = 0;
        for (int k = 0; k < K; k++) begin
            logic signed [N-1:0] x;
            x = d[k*N +: N];
            s += coef[k] * longint'(x);
        end
        return s;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // behavioural reference model
    bit     m_busy = 0, m_valid = 0;
    int     m_cnt = 0;
    longint m_res = 0, m_pend = 0;

    always @(posedge clk) begin
        bit take;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_cnt = 0; m_res = 0;
        end else begin
            take = start && !m_busy;
            m_valid = 0;
            if (m_busy) begin
                if (m_cnt == N-1) begin
                    m_busy = 0; m_valid = 1; m_res = m_pend;
                end else begin
                    m_cnt++;
                end
            end
            if (take) begin
                m_pend = dot_f(din); m_busy = 1; m_cnt = 0;
            end
        end
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_tag, "/R8 busy"},   longint'(busy),   longint'(m_busy));
            check({cur_tag, "/R2 valid"},  longint'(valid),  longint'(m_valid));
            check({cur_tag, "/R9 result"}, longint'(result), m_res);
        end
    end

    task automatic run_one(input string tag, input logic [K*N-1:0] d, input longint exp);
        @(negedge clk); din = d; start = 1'b1;
        @(negedge clk); start = 1'b0; din = ~d;
        repeat (N) @(negedge clk);
        check({tag, " valid at N"}, longint'(valid), 1);
        check({tag, " result"}, longint'(result), exp);
    endtask

    function automatic logic [K*N-1:0] lanes(input int a0, input int a1, input int a2, input int a3);
        logic [K*N-1:0] d;
        d[0*N +: N] = N'(a0); d[1*N +: N] = N'(a1);
        d[2*N +: N] = N'(a2); d[3*N +: N] = N'(a3);
        return d;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset",   longint'(busy),   0);
        check("R1 valid in reset",  longint'(valid),  0);
        check("R1 result in reset", longint'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset",   longint'(busy),   0);
        check("R1 result after reset", longint'(result), 0);

        cur_tag = "R4";
        run_one("R4 idx 1111", lanes(1, 1, 1, 1), 24248);
        run_one("R4 idx 0110", lanes(0, 1, 1, 0), 10650);
        run_one("R4 idx 0101", lanes(0, 1, 0, 1), -3113);

        cur_tag = "R5";
        run_one("R5 sign lane0", lanes(-128, 0, 0, 0), -11796 * 128);
        run_one("R5 sign lane1", lanes(0, -128, 0, 0), 4915 * 128);

        cur_tag = "R3";
        run_one("R3 all min", lanes(-128, -128, -128, -128), -24248 * 128);
        run_one("R3 all max", lanes(127, 127, 127, 127), 24248 * 127);
        run_one("R3 mixed", lanes(64, -1, 37, -100), dot_f(lanes(64, -1, 37, -100)));

        // start during busy must be ignored, din changes ignored
        cur_tag = "R6";
        @(negedge clk); din = lanes(5, 6, 7, 8); start = 1'b1;
        @(negedge clk); start = 1'b0; din = lanes(-9, 100, 3, 3);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (N - 5) @(negedge clk);
        start = 1'b1;   // present at the sign-bit edge: ignored
        @(negedge clk); start = 1'b0;
        check("R6 valid after ignored starts", longint'(valid), 1);
        check("R6 result from first capture", longint'(result), dot_f(lanes(5, 6, 7, 8)));
        @(negedge clk);
        check("R6 idle after late start", longint'(busy), 0);

        // continuous start: accepted in each valid cycle
        cur_tag = "R7";
        start = 1'b1;
        for (int i = 0; i < 10 * (N + 1); i++) begin
            din = K*N'($urandom());
            @(negedge clk);
        end
        start = 1'b0;
        repeat (N + 2) @(negedge clk);

        // random traffic
        cur_tag = "R3";
        for (int t = 0; t < 300; t++) begin
            din = K*N'($urandom());
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat ($urandom_range(0, N + 3)) begin
                din = K*N'($urandom());
                start = ($urandom_range(0, 5) == 0);
                @(negedge clk);
            end
            start = 1'b0;
        end
        repeat (N + 2) @(negedge clk);
        finish_run();
    end
endmodule